// File: doc/BRIEF.md
# Destination Address Filter with Group Hash

This block sits on the receive side of an Ethernet MAC and rules on each incoming frame from its 48-bit destination address alone. The address is presented one byte per cycle, first byte on the wire first, with a start strobe on that first byte. One cycle after the sixth byte the block raises a one-cycle valid pulse together with an accept or reject verdict.

Three rules decide the verdict. An individual (unicast) address is accepted only when it equals the programmed station address in all 48 bits. A group address (least significant bit of the first byte set) is looked up in a table of single-bit bins. The bin index comes from a CRC-32 computed over the address bytes while they stream in. The all-ones broadcast address always passes. A promiscuous switch overrides everything. A small write-only configuration port loads the station address, sets or clears one bin per write, and controls the promiscuous switch.

Top module: `mhf_filter`

## Requirements
- R1: After reset every bin is clear, promiscuous mode is off and the station address is all zero. A group address or a non-zero unicast address is then rejected, and no verdict is signalled before an address has been received.
- R2: The verdict valid pulse is high for exactly one cycle, the cycle after the clock edge that samples the sixth address byte. It is low while the first five bytes are being received.
- R3: A unicast address equal to the station address in all 48 bits is accepted.
- R4: A unicast address that differs from the station address in any bit is rejected.
- R5: A group address whose bin is set is accepted. The bin index is formed as follows. Run the reflected CRC-32 (polynomial 0xEDB88320 in shift-right form), seeded with all ones and with no final inversion, over the six bytes in wire order. Bit-reverse the 32-bit result and take bits 31:23 of the reversed value.
- R6: A group address whose bin is clear is rejected (unless it is broadcast or promiscuous mode is on).
- R7: A write with selector 3 takes the bin index from wdata[8:0] and the new bin value from wdata[9] (1 sets, 0 clears). All other bins keep their values.
- R8: Unicast addresses never consult the bin table: a set bin at a unicast address's index does not make it pass.
- R9: The broadcast address FF:FF:FF:FF:FF:FF is always accepted.
- R10: A write with selector 0 sets promiscuous mode from wdata[0]. While it is on, every address is accepted.
- R11: A start strobe in the middle of an address discards the partial address and re-seeds the CRC. Only the six bytes that follow the latest strobe decide the verdict.
- R12: The station address is written with selector 1 (address bytes 0..3, byte 0 in bits 7:0, byte 3 in bits 31:24) and selector 2 (byte 4 in bits 7:0, byte 5 in bits 15:8). Byte 0 is the first byte on the wire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register selector |
| cfg_wdata | input | 32 | Configuration write data |
| da_start | input | 1 | Marks the first destination address byte |
| da_valid | input | 1 | Destination address byte is present |
| da_byte | input | 8 | Destination address byte |
| dec_valid | output | 1 | One-cycle verdict pulse |
| dec_accept | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
The bench computes bin indices with its own bit-serial CRC. A design that reversed the CRC wrongly, took the wrong nine bits or forgot the all-ones seed would then accept a group address from a bin that was never set, and reject the one that was. Four further cases are aimed at. A unicast address that differs only in its last bit must fail, which a design that compared a partial address would miss. A set bin at a unicast address's index must not help it, which catches a filter that looks up the table for every address. Clearing one bin must leave a neighbouring set bin intact. A restart strobe after three bytes must re-seed the CRC, or a leftover partial address would corrupt the verdict. The bench also checks the exact verdict cycle and the single-cycle width of the pulse.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

   // bytes in a destination address
   localparam int unsigned ADDR_BYTES = 6;
   localparam int unsigned ADDR_W     = ADDR_BYTES * 8;
   localparam int unsigned CRC_W      = 32;

   // configuration selector values
   typedef enum logic [1:0] {
      SEL_MODE   = 2'd0,
      SEL_STA_LO = 2'd1,
      SEL_STA_HI = 2'd2,
      SEL_BIN    = 2'd3
   } cfg_sel_e;

   localparam logic [CRC_W-1:0] CRC_POLY_RFL = 32'hEDB8_8320;
   localparam logic [CRC_W-1:0] CRC_SEED     = 32'hFFFF_FFFF;

   // one byte of reflected CRC-32, least significant bit first
   function automatic logic [CRC_W-1:0] crc_byte_step(input logic [CRC_W-1:0] c_in,
                                                      input logic [7:0]       b);
      logic [CRC_W-1:0] c;
      c = c_in ^ {24'd0, b};
      for (int k = 0; k < 8; k++) begin
         if (c[0]) c = (c >> 1) ^ CRC_POLY_RFL;
         else      c = c >> 1;
      end
      return c;
   endfunction

   function automatic logic [CRC_W-1:0] bit_flip32(input logic [CRC_W-1:0] v);
      logic [CRC_W-1:0] r;
      for (int k = 0; k < CRC_W; k++) r[k] = v[CRC_W-1-k];
      return r;
   endfunction

endpackage

// File: rtl/mhf_cfg_regs.sv
module mhf_cfg_regs
   import mhf_pkg::*;
#(
   parameter int unsigned IDX_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        sel,
   input  logic [31:0]       wdata,
   output logic [ADDR_W-1:0] station,
   output logic              promisc,
   output logic              bin_we,
   output logic [IDX_W-1:0]  bin_idx,
   output logic              bin_val
);

   logic [31:0] sta_lo_q;
   logic [15:0] sta_hi_q;
   logic        promisc_q;
   cfg_sel_e    sel_e;

   assign sel_e = cfg_sel_e'(sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sta_lo_q  <= '0;
         sta_hi_q  <= '0;
         promisc_q <= 1'b0;
      end else if (we) begin
         case (sel_e)
            SEL_MODE:   promisc_q <= wdata[0];
            SEL_STA_LO: sta_lo_q  <= wdata;
            SEL_STA_HI: sta_hi_q  <= wdata[15:0];
            default:    ;
         endcase
      end
   end

   // byte 0 of the wire order sits in the low byte
   assign station = {sta_hi_q, sta_lo_q};
   assign promisc = promisc_q;

   // bin writes pass straight through to the table
   assign bin_we  = we && (sel_e == SEL_BIN);
   assign bin_idx = wdata[IDX_W-1:0];
   assign bin_val = wdata[IDX_W];

   logic unused_wbits;
   assign unused_wbits = ^{wdata[31:IDX_W+1]};

   // R10
   property promisc_load_p;
      @(posedge clk) disable iff (!rst_n)
         (we && sel_e == SEL_MODE) |=> (promisc == $past(wdata[0]));
   endproperty
   promisc_load_chk: assert property (promisc_load_p);

endmodule

// File: rtl/mhf_bin_table.sv
module mhf_bin_table #(
   parameter int unsigned IDX_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_val,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_hit
);

   localparam int unsigned NBINS = 1 << IDX_W;

   logic [NBINS-1:0] bins_q;

   for (genvar g = 0; g < NBINS; g++) begin : g_bin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bins_q[g] <= 1'b0;
         else if (wr_en && (wr_idx == IDX_W'(g)))
            bins_q[g] <= wr_val;
      end
   end

   assign rd_hit = bins_q[rd_idx];

   // R7
   property bin_write_p;
      @(posedge clk) disable iff (!rst_n)
         wr_en |=> (bins_q[$past(wr_idx)] == $past(wr_val));
   endproperty
   bin_write_chk: assert property (bin_write_p);

   // R7: at most one bin moves per cycle
   property bin_single_p;
      @(posedge clk) disable iff (!rst_n)
         ##1 $countones(bins_q ^ $past(bins_q)) <= 1;
   endproperty
   bin_single_chk: assert property (bin_single_p);

endmodule

// File: rtl/mhf_crc_acc.sv
module mhf_crc_acc
   import mhf_pkg::*;
#(
   parameter int unsigned IDX_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             valid,
   input  logic [7:0]       data,
   output logic [IDX_W-1:0] idx
);

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_base;
   logic [CRC_W-1:0] crc_next;
   logic [CRC_W-1:0] crc_rev;

   // a start strobe discards whatever was accumulated
   assign crc_base = start ? CRC_SEED : crc_q;
   assign crc_next = crc_byte_step(crc_base, data);
   assign crc_rev  = bit_flip32(crc_next);
   assign idx      = crc_rev[CRC_W-1 -: IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= CRC_SEED;
      else if (valid) crc_q <= crc_next;
   end

   logic unused_rev;
   assign unused_rev = ^{crc_rev[CRC_W-IDX_W-1:0]};

   // R11
   property crc_hold_p;
      @(posedge clk) disable iff (!rst_n)
         !valid |=> $stable(crc_q);
   endproperty
   crc_hold_chk: assert property (crc_hold_p);

endmodule

// File: rtl/mhf_da_collect.sv
module mhf_da_collect
   import mhf_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              valid,
   input  logic [7:0]        data,
   output logic              last,
   output logic [ADDR_W-1:0] full_addr
);

   localparam int unsigned CNT_W  = $clog2(ADDR_BYTES);
   localparam int unsigned HELD_N = ADDR_BYTES - 1;

   logic [CNT_W-1:0] cnt_q;     // bytes taken so far, 0 when idle
   logic [7:0]       held_q [HELD_N];
   logic             busy;

   assign busy = (cnt_q != '0);
   assign last = valid && !start && (cnt_q == CNT_W'(ADDR_BYTES-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (valid && start)
         cnt_q <= CNT_W'(1);
      else if (last)
         cnt_q <= '0;
      else if (valid && busy)
         cnt_q <= cnt_q + CNT_W'(1);
   end

   for (genvar g = 0; g < HELD_N; g++) begin : g_held
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            held_q[g] <= '0;
         else if (valid && start && g == 0)
            held_q[g] <= data;
         else if (valid && !start && busy && cnt_q == CNT_W'(g))
            held_q[g] <= data;
      end
      assign full_addr[8*g +: 8] = held_q[g];
   end
   assign full_addr[ADDR_W-1 -: 8] = data;

   // R2
   property back_to_idle_p;
      @(posedge clk) disable iff (!rst_n)
         last |=> (cnt_q == '0);
   endproperty
   back_to_idle_chk: assert property (back_to_idle_p);

   // R11
   property restart_p;
      @(posedge clk) disable iff (!rst_n)
         (valid && start) |=> (cnt_q == CNT_W'(1));
   endproperty
   restart_chk: assert property (restart_p);

endmodule

// File: rtl/mhf_filter.sv
module mhf_filter
   import mhf_pkg::*;
#(
   parameter int unsigned IDX_W = 9
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [1:0]  cfg_sel,
   input  logic [31:0] cfg_wdata,
   input  logic        da_start,
   input  logic        da_valid,
   input  logic [7:0]  da_byte,
   output logic        dec_valid,
   output logic        dec_accept
);

   // the bin value bit rides just above the index, inside one data word
   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("mhf_filter: IDX_W must lie in 1..12");
   end

   logic [ADDR_W-1:0] station;
   logic              promisc;
   logic              bin_we;
   logic [IDX_W-1:0]  bin_idx;
   logic              bin_val;
   logic [IDX_W-1:0]  look_idx;
   logic              bin_hit;
   logic              last;
   logic [ADDR_W-1:0] full_addr;
   logic              is_group;
   logic              is_bcast;
   logic              uc_hit;
   logic              verdict;
   logic              dec_valid_q;
   logic              dec_accept_q;

   mhf_cfg_regs #(.IDX_W(IDX_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .sel     (cfg_sel),
      .wdata   (cfg_wdata),
      .station (station),
      .promisc (promisc),
      .bin_we  (bin_we),
      .bin_idx (bin_idx),
      .bin_val (bin_val)
   );

   mhf_bin_table #(.IDX_W(IDX_W)) u_bins (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bin_we),
      .wr_idx (bin_idx),
      .wr_val (bin_val),
      .rd_idx (look_idx),
      .rd_hit (bin_hit)
   );

   mhf_crc_acc #(.IDX_W(IDX_W)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .start (da_start),
      .valid (da_valid),
      .data  (da_byte),
      .idx   (look_idx)
   );

   mhf_da_collect u_col (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (da_start),
      .valid     (da_valid),
      .data      (da_byte),
      .last      (last),
      .full_addr (full_addr)
   );

   assign is_group = full_addr[0];
   assign is_bcast = &full_addr;
   assign uc_hit   = (full_addr == station);

   always_comb begin
      if (promisc || is_bcast) verdict = 1'b1;
      else if (is_group)       verdict = bin_hit;
      else                     verdict = uc_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid_q  <= 1'b0;
         dec_accept_q <= 1'b0;
      end else begin
         dec_valid_q <= last;
         if (last) dec_accept_q <= verdict;
      end
   end

   assign dec_valid  = dec_valid_q;
   assign dec_accept = dec_accept_q;

   // R2
   property pulse_one_p;
      @(posedge clk) disable iff (!rst_n)
         dec_valid |=> !dec_valid;
   endproperty
   pulse_one_chk: assert property (pulse_one_p);

   // R2
   property pulse_after_byte_p;
      @(posedge clk) disable iff (!rst_n)
         dec_valid |-> $past(da_valid);
   endproperty
   pulse_after_byte_chk: assert property (pulse_after_byte_p);

   // R9
   property bcast_pass_p;
      @(posedge clk) disable iff (!rst_n)
         $past(last && is_bcast) |-> (dec_valid && dec_accept);
   endproperty
   bcast_pass_chk: assert property (bcast_pass_p);

   // R10
   property promisc_pass_p;
      @(posedge clk) disable iff (!rst_n)
         $past(last && promisc) |-> (dec_valid && dec_accept);
   endproperty
   promisc_pass_chk: assert property (promisc_pass_p);

   // R6
   property group_miss_p;
      @(posedge clk) disable iff (!rst_n)
         $past(last && is_group && !is_bcast && !promisc && !bin_hit)
            |-> (dec_valid && !dec_accept);
   endproperty
   group_miss_chk: assert property (group_miss_p);

   // R8
   property ucast_table_p;
      @(posedge clk) disable iff (!rst_n)
         $past(last && !is_group && !promisc && !uc_hit) |-> !dec_accept;
   endproperty
   ucast_table_chk: assert property (ucast_table_p);

endmodule

// File: tb/mhf_filter_bench.sv
module mhf_filter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        da_start = 1'b0;
   logic        da_valid = 1'b0;
   logic [7:0]  da_byte = '0;
   logic        dec_valid;
   logic        dec_accept;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   mhf_filter u_mhf_filter (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .da_start   (da_start),
      .da_valid   (da_valid),
      .da_byte    (da_byte),
      .dec_valid  (dec_valid),
      .dec_accept (dec_accept)
   );

   // byte 0 of the wire order is [7:0]
   localparam logic [47:0] STA   = 48'h5544_3322_1102;
   localparam logic [47:0] MC_A  = 48'h0100_005E_0001;
   localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // bit-serial reference of the bin index
   function automatic logic [8:0] ref_idx(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      logic [31:0] r;
      for (int i = 0; i < 48; i++) begin
         logic fb = c[0] ^ a[i];
         c = {1'b0, c[31:1]};
         if (fb) c = c ^ 32'hEDB8_8320;
      end
      for (int k = 0; k < 32; k++) r[31-k] = c[k];
      return r[31:23];
   endfunction

   task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_bin(input logic [8:0] idx, input bit v);
      cfg_write(2'd3, {22'd0, v, idx});
   endtask

   task automatic send_part(input logic [47:0] a, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         da_valid = 1'b1; da_start = (i == 0); da_byte = a[8*i +: 8];
      end
      @(negedge clk);
      da_valid = 1'b0; da_start = 1'b0;
   endtask

   // drives six bytes, checks the pulse timing and the verdict
   task automatic send_chk(input logic [47:0] a, input bit exp, input string tag);
      bit early = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (dec_valid) early = 1'b1;
         da_valid = 1'b1; da_start = (i == 0); da_byte = a[8*i +: 8];
      end
      @(negedge clk);
      da_valid = 1'b0; da_start = 1'b0;
      check(!early, "R2 no pulse during bytes", 32'(early), 0);
      check(dec_valid === 1'b1, "R2 pulse one cycle after sixth byte", 32'(dec_valid), 1);
      check(dec_accept === exp, tag, 32'(dec_accept), 32'(exp));
      @(negedge clk);
      check(dec_valid === 1'b0, "R2 pulse lasts one cycle", 32'(dec_valid), 0);
   endtask

   task automatic t_reset();
      check(dec_valid === 1'b0, "R1 no verdict after reset", 32'(dec_valid), 0);
      send_chk(MC_A, 1'b0, "R1 group rejected with clear bins");
      send_chk(STA, 1'b0, "R1 unicast rejected with zero station");
   endtask

   task automatic t_station();
      cfg_write(2'd1, 32'h3322_1102);   // R12 bytes 0..3
      cfg_write(2'd2, 32'h0000_5544);   // R12 bytes 4..5
      send_chk(STA, 1'b1, "R3 R12 station match accepted");
   endtask

   task automatic t_ucast_miss();
      send_chk(STA ^ 48'h8000_0000_0000, 1'b0, "R4 last bit differs rejected");
      send_chk(STA ^ 48'h0000_0000_0002, 1'b0, "R4 first byte differs rejected");
   endtask

   task automatic t_hash();
      logic [47:0] mc_b = MC_A;
      logic [8:0]  ia = ref_idx(MC_A);
      logic [8:0]  ib;
      mc_b[47:40] = 8'h02;
      ib = ref_idx(mc_b);
      while (ib == ia) begin
         mc_b[47:40] = mc_b[47:40] + 8'd1;
         ib = ref_idx(mc_b);
      end
      set_bin(ia, 1'b1);
      send_chk(MC_A, 1'b1, "R5 group with set bin accepted");
      send_chk(mc_b, 1'b0, "R6 group with clear bin rejected");
      set_bin(ib, 1'b1);
      set_bin(ia, 1'b0);
      send_chk(MC_A, 1'b0, "R7 cleared bin rejects");
      send_chk(mc_b, 1'b1, "R7 other bin kept");
      set_bin(ib, 1'b0);
      send_chk(mc_b, 1'b0, "R7 bin cleared again");
   endtask

   task automatic t_ucast_table();
      logic [47:0] u = 48'h0A09_0807_0604;
      set_bin(ref_idx(u), 1'b1);
      send_chk(u, 1'b0, "R8 unicast ignores table");
      set_bin(ref_idx(u), 1'b0);
   endtask

   task automatic t_bcast();
      send_chk(BCAST, 1'b1, "R9 broadcast accepted");
   endtask

   task automatic t_promisc();
      cfg_write(2'd0, 32'h1);
      send_chk(48'h0A09_0807_0604, 1'b1, "R10 promisc unicast accepted");
      send_chk(MC_A, 1'b1, "R10 promisc group accepted");
      cfg_write(2'd0, 32'h0);
      send_chk(MC_A, 1'b0, "R10 promisc off group rejected");
   endtask

   task automatic t_restart();
      set_bin(ref_idx(MC_A), 1'b1);
      send_part(48'h0000_0000_0000, 3);
      send_chk(MC_A, 1'b1, "R11 restart reseeds CRC");
      send_part(STA, 4);
      send_chk(STA ^ 48'h0100_0000_0000, 1'b0, "R11 restart drops old bytes");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_station();
      t_ucast_miss();
      t_hash();
      t_ucast_table();
      t_bcast();
      t_promisc();
      t_restart();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule